// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block turns event inputs into latched secondary status bits and folds those bits into three primary interrupt flags and one chip-level interrupt line. There are twelve general-purpose input lines, one thermal-warning level and one on-button input. All inputs are already synchronous to `clk`.

Each secondary bit has a mask bit. A status bit latches its event whether or not it is masked. A primary flag is raised only while an unmasked status bit in its group is set. Software reads status and mask words through a small register port. It clears status bits by writing ones and programs masks by plain writes.

Each general-purpose input has its own 2-bit trigger mode. The thermal warning sets its bit on every change of level. The on-button input sets its bit on a rising edge.

Top module: `irq_two_level`

## Requirements
- R1: Each primary flag is high exactly while some status bit of its group is 1 and its mask bit is 0. A mask bit of 1 keeps that bit from raising its flag. The flags change in the cycle after the status or mask register changes.
- R2: A status bit latches its event whatever the value of its mask bit. The bit stays set until it is cleared.
- R3: Out of reset, every mask bit is 1 and every status bit is 0. All interrupt outputs are low. The edge detectors take every input as 0.
- R4: A write of 1 to a status bit clears it at the write edge. A write of 0 leaves the bit unchanged.
- R5: The thermal status bit sets on both rising and falling changes of `therm_warn`. A change is judged against the level sampled at the previous clock edge.
- R6: General-purpose input i sets status bit i according to `gpio_mode[2i+1:2i]`: 00 sets on a rising edge, 01 on a falling edge, 10 on either edge, and 11 on every cycle the input is high.
- R7: When an event and a write-1-clear hit the same status bit in one cycle, the bit ends up 1.
- R8: A rising edge on `onkey_in` sets the on-button status bit. The thermal bit drives only `therm_irq` and the on-button bit drives only `onkey_irq`.
- R9: `chip_irq` is active high and level sensitive. It is the OR of `therm_irq`, `gpio_irq` and `onkey_irq`.
- R10: There are four register words. Address 0 is the combined status, with the thermal bit at bit 1 and the on-button bit at bit 0. Address 1 is the GPIO status in bits 11:0. Address 2 is the combined mask, laid out like address 0. Address 3 is the GPIO mask. Unused read bits are 0. `reg_rdata` shows the word in the cycle after `reg_rd`, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpio_in | input | 12 | General-purpose event inputs |
| gpio_mode | input | 24 | Trigger mode, two bits per input |
| therm_warn | input | 1 | Thermal-warning level |
| onkey_in | input | 1 | On-button level |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data, valid the cycle after `reg_rd` |
| therm_irq | output | 1 | Thermal primary flag |
| gpio_irq | output | 1 | GPIO primary flag |
| onkey_irq | output | 1 | On-button primary flag |
| chip_irq | output | 1 | Chip interrupt line |

## Verification
A wrong edge-detector history or a wrongly latched status bit shows on a primary flag one cycle after the triggering input change, provided that bit is unmasked. If the bit is masked, the fault shows only through a status read, one cycle after the read strobe. A lost clear or a clear that beats a coincident event leaves a flag high, or drops it, in the cycle after the write. A reference model is therefore compared against every flag on every cycle and against every read word. Random traffic keeps masks, modes and clears varied, so that masked faults do not stay hidden for long.

// File: rtl/irq_two_level.sv
module irq_two_level #(
  parameter int NUM_GPIO = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GPIO-1:0]   gpio_in,
  input  logic [2*NUM_GPIO-1:0] gpio_mode,
  input  logic                  therm_warn,
  input  logic                  onkey_in,
  input  logic [1:0]            reg_addr,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [NUM_GPIO-1:0]   reg_wdata,
  output logic [NUM_GPIO-1:0]   reg_rdata,
  output logic                  therm_irq,
  output logic                  gpio_irq,
  output logic                  onkey_irq,
  output logic                  chip_irq
);
  localparam logic [1:0] A_MST = 2'd0, A_GST = 2'd1, A_MMSK = 2'd2, A_GMSK = 2'd3;

  logic [NUM_GPIO-1:0] gpio_prev, gpio_st, gpio_mask, gpio_evt, gpio_clr;
  logic                therm_prev, onkey_prev;
  logic [1:0]          misc_st, misc_mask, misc_evt, misc_clr;
  logic [NUM_GPIO-1:0] rd_mux;

  always_comb begin
    for (int i = 0; i < NUM_GPIO; i++) begin
      unique case (gpio_mode[2*i +: 2])
        2'b00:   gpio_evt[i] = gpio_in[i] & ~gpio_prev[i];
        2'b01:   gpio_evt[i] = ~gpio_in[i] & gpio_prev[i];
        2'b10:   gpio_evt[i] = gpio_in[i] ^ gpio_prev[i];
        default: gpio_evt[i] = gpio_in[i];
      endcase
    end
  end

  assign misc_evt = {therm_warn ^ therm_prev, onkey_in & ~onkey_prev};
  assign gpio_clr = (reg_wr && reg_addr == A_GST) ? reg_wdata : '0;
  assign misc_clr = (reg_wr && reg_addr == A_MST) ? reg_wdata[1:0] : 2'b00;

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      A_MST:   rd_mux[1:0] = misc_st;
      A_GST:   rd_mux      = gpio_st;
      A_MMSK:  rd_mux[1:0] = misc_mask;
      default: rd_mux      = gpio_mask;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpio_prev  <= '0;
      therm_prev <= 1'b0;
      onkey_prev <= 1'b0;
      gpio_st    <= '0;
      misc_st    <= 2'b00;
      gpio_mask  <= '1;
      misc_mask  <= 2'b11;
      reg_rdata  <= '0;
    end else begin
      gpio_prev  <= gpio_in;
      therm_prev <= therm_warn;
      onkey_prev <= onkey_in;
      gpio_st    <= (gpio_st & ~gpio_clr) | gpio_evt;
      misc_st    <= (misc_st & ~misc_clr) | misc_evt;
      if (reg_wr && reg_addr == A_GMSK) gpio_mask <= reg_wdata;
      if (reg_wr && reg_addr == A_MMSK) misc_mask <= reg_wdata[1:0];
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  assign therm_irq = misc_st[1] & ~misc_mask[1];
  assign onkey_irq = misc_st[0] & ~misc_mask[0];
  assign gpio_irq  = |(gpio_st & ~gpio_mask);
  assign chip_irq  = therm_irq | gpio_irq | onkey_irq;

  p_mask_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (&gpio_mask && &misc_mask) |-> !chip_irq);
  p_status_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_GST) |=> ((gpio_st & $past(gpio_st)) == $past(gpio_st)));
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_GST && reg_wdata[0] && !gpio_evt[0]) |=> !gpio_st[0]);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|gpio_evt) |=> ((gpio_st & $past(gpio_evt)) == $past(gpio_evt)));
  p_therm_sep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (misc_evt == 2'b10 && misc_st[0] == 1'b0 && !(reg_wr && reg_addr == A_MST)) |=> !onkey_irq);
  p_rd_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_GMSK) |=> (reg_rdata == $past(gpio_mask)));
endmodule

// File: tb/irq_two_level_tb_top.sv
module irq_two_level_tb_top;
  localparam int NG = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NG-1:0] gpio = '0, wdata = '0;
  logic [2*NG-1:0] mode = '0;
  logic tw = 1'b0, ok = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [NG-1:0] rdata;
  logic t_irq, g_irq, o_irq, c_irq;
  int n_chk = 0, n_bad = 0;

  logic [NG-1:0] m_gprev, m_gst, m_gmask, m_rd;
  logic m_tprev, m_oprev;
  logic [1:0] m_mst, m_mmask;
  logic m_rdv;

  always #5ns clk = ~clk;

  irq_two_level #(.NUM_GPIO(NG)) dut_i (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio), .gpio_mode(mode),
    .therm_warn(tw), .onkey_in(ok), .reg_addr(addr), .reg_wr(wr),
    .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata),
    .therm_irq(t_irq), .gpio_irq(g_irq), .onkey_irq(o_irq), .chip_irq(c_irq));

  function automatic logic [NG-1:0] exp_gevt(logic [NG-1:0] cur, logic [NG-1:0] prv, logic [2*NG-1:0] md);
    logic [NG-1:0] e;
    for (int i = 0; i < NG; i++)
      case (md[2*i +: 2])
        2'b00: e[i] = cur[i] && !prv[i];
        2'b01: e[i] = !cur[i] && prv[i];
        2'b10: e[i] = cur[i] != prv[i];
        default: e[i] = cur[i];
      endcase
    return e;
  endfunction

  function automatic logic [NG-1:0] exp_word(logic [1:0] a);
    case (a)
      2'd0: return {{(NG-2){1'b0}}, m_mst};
      2'd1: return m_gst;
      2'd2: return {{(NG-2){1'b0}}, m_mmask};
      default: return m_gmask;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [NG-1:0] act, input logic [NG-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_gprev = '0; m_tprev = 0; m_oprev = 0; m_gst = '0; m_mst = 0;
    m_gmask = '1; m_mmask = 2'b11; m_rd = '0; m_rdv = 0;
  endtask

  // inputs are set; advance model across the next edge, then compare at negedge
  task automatic step();
    logic [NG-1:0] ge, gclr; logic [1:0] me, mclr;
    ge = exp_gevt(gpio, m_gprev, mode);
    me = {tw != m_tprev, ok && !m_oprev};
    gclr = (wr && addr == 2'd1) ? wdata : '0;
    mclr = (wr && addr == 2'd0) ? wdata[1:0] : 2'b00;
    m_rdv = rd;
    if (rd) m_rd = exp_word(addr);
    @(posedge clk);
    m_gst = (m_gst & ~gclr) | ge;
    m_mst = (m_mst & ~mclr) | me;
    if (wr && addr == 2'd3) m_gmask = wdata;
    if (wr && addr == 2'd2) m_mmask = wdata[1:0];
    m_gprev = gpio; m_tprev = tw; m_oprev = ok;
    @(negedge clk);
    chk("R1 therm_irq", NG'(t_irq), NG'(m_mst[1] && !m_mmask[1]));
    chk("R1 onkey_irq", NG'(o_irq), NG'(m_mst[0] && !m_mmask[0]));
    chk("R1 gpio_irq", NG'(g_irq), NG'(|(m_gst & ~m_gmask)));
    chk("R9 chip_irq", NG'(c_irq), NG'((m_mst & ~m_mmask) != 0 || (m_gst & ~m_gmask) != 0));
    if (m_rdv) chk("R10 rdata", rdata, m_rd);
    wr = 0; rd = 0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [NG-1:0] d);
    wr = 1; addr = a; wdata = d; step();
  endtask

  task automatic rreg(input logic [1:0] a);
    rd = 1; addr = a; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R3 chip_irq in reset", NG'(c_irq), '0);
    rst_n = 1;
    rreg(2'd2); chk("R3 combined mask", rdata, 12'h003);
    rreg(2'd3); chk("R3 gpio mask", rdata, 12'hfff);
    rreg(2'd1); chk("R3 gpio status", rdata, 12'h000);

    // R6 rising edge unmasked, R4 clear with input still high
    wreg(2'd3, 12'hffe);
    gpio[0] = 1; step();
    chk("R6 rise raises gpio_irq", NG'(g_irq), 12'h001);
    chk("R9 chip_irq follows", NG'(c_irq), 12'h001);
    wreg(2'd1, 12'h000); chk("R4 write 0 keeps", NG'(g_irq), 12'h001);
    wreg(2'd1, 12'h001); chk("R4 write 1 clears", NG'(g_irq), 12'h000);

    // R2 masked event still latches
    gpio[1] = 1; step();
    chk("R2 masked no irq", NG'(g_irq), 12'h000);
    rreg(2'd1); chk("R2 masked bit latched", rdata, 12'h002);

    // R6 falling mode on input 3, R7 level mode on input 2 with clear
    mode[7:6] = 2'b01; gpio[3] = 1; step(); rreg(2'd1);
    chk("R6 falling mode ignores rise", rdata & 12'h008, 12'h000);
    gpio[3] = 0; step(); rreg(2'd1);
    chk("R6 falling mode sets", rdata & 12'h008, 12'h008);
    mode[5:4] = 2'b11; gpio[2] = 1; step();
    wreg(2'd1, 12'h004); rreg(2'd1);
    chk("R7 set wins over clear", rdata & 12'h004, 12'h004);

    // R5 thermal both edges, R8 separation
    wreg(2'd0, 12'h003); wreg(2'd2, 12'h001);
    tw = 1; step();
    chk("R5 thermal rise", NG'(t_irq), 12'h001);
    chk("R8 onkey untouched", NG'(o_irq), 12'h000);
    wreg(2'd0, 12'h002); chk("R4 thermal cleared", NG'(t_irq), 12'h000);
    tw = 0; step();
    chk("R5 thermal fall", NG'(t_irq), 12'h001);
    wreg(2'd2, 12'h002); ok = 1; step();
    chk("R8 onkey press", NG'(o_irq), 12'h001);
    chk("R8 thermal now masked", NG'(t_irq), 12'h000);
    rreg(2'd0); chk("R10 combined status bits", rdata, 12'h003);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) mode = {$urandom, $urandom} & {(2*NG){1'b1}};
      gpio = gpio ^ (NG'($urandom) & NG'($urandom) & NG'($urandom));
      if ($urandom % 8 == 0) tw = ~tw;
      if ($urandom % 8 == 0) ok = ~ok;
      wr = ($urandom % 4 == 0);
      rd = ($urandom % 2 == 0);
      addr = 2'($urandom);
      wdata = NG'($urandom);
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule